// File: doc/BRIEF.md
# Crossbar Row Write Pulse Sequencer

This block plans the write pulses that store one training example in a resistive crossbar. A start strobe latches a row number, a mode bit and one target value per column. The selected row is first erased with a single positive pulse that takes every cell on that row to low resistance. The sequencer then issues negative pulses that raise the resistance of chosen cells only. Each crossbar line gets a two-bit drive code each cycle. The analog drivers turn these codes into voltages. The analog drivers and the cell physics are outside this block.

The block protects half-selected cells with a one-third bias scheme. While a pulse is on, the selected row runs at full amplitude and every other row sits at one-third amplitude. Each column runs at either full or one-third amplitude. Only a cell whose row and column both run at full amplitude sees the whole write voltage.

In binary mode there is one negative pulse, and the columns with a nonzero target are fully driven. In multilevel mode there is a fixed train of negative pulses, as many as the largest level. The target of a column sets how many of the leading pulses in that train drive the column fully. A larger target gives a lower final conductance. A fixed gap of idle cycles lies between consecutive pulses. Each pulse lasts a parameterised number of clock cycles, which gives a 100 ns pulse at the default clock.

Top module: `xbar_write_seq`

## Requirements
- R1: After reset, and whenever neither busy nor done is high, every row and column drive code is OFF (code 0) and negPulse is low.
- R2: The block accepts start only when busy and done are both low. It captures rowSel, multiLevel and colTarget on that edge and raises busy on the next cycle. A start during a write is ignored, and the write in progress continues with the values captured at its start.
- R3: The first pulse of a write is the erase pulse. It lasts PULSE_CYCLES cycles with negPulse low. The selected row is FULL (code 1), every other row is THIRD (code 2), and every column is FULL.
- R4: Between consecutive pulses there are exactly GAP_CYCLES cycles in which busy stays high, every drive code is OFF and negPulse is low.
- R5: In binary mode (multiLevel=0), a single negative pulse of PULSE_CYCLES cycles follows the erase gap. During it negPulse is high, the selected row is FULL and the other rows are THIRD. A column with a nonzero target is FULL and a column whose target is zero is THIRD.
- R6: In multilevel mode (multiLevel=1), 2^LEVEL_W-1 negative pulses follow the erase gap. These are numbered k = 0, 1, and so on. In pulse k, a column is FULL when k is less than its target and THIRD otherwise. The rows are driven as in R5.
- R7: In the cycle right after the last negative pulse, done is high for exactly one cycle, busy is low and every drive code is OFF. In the cycle after that the block is idle.
- R8: The code 3, which is kept for read pulses, never appears on any row or column.
- R9: While any row is driven, exactly one row carries FULL, and it stays the same row for the whole write.
- R10: Column c takes its target from bits colTarget[c*LEVEL_W +: LEVEL_W]. Lane i of rowDrive and colDrive is carried on bits [2*i+1:2*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe for a row write |
| rowSel | input | ROW_W | Row to write |
| multiLevel | input | 1 | 1 = multilevel, 0 = binary |
| colTarget | input | NUM_COLS*LEVEL_W | Per-column target values |
| rowDrive | output | NUM_ROWS*2 | Per-row drive code |
| colDrive | output | NUM_COLS*2 | Per-column drive code |
| negPulse | output | 1 | Polarity: 1 for negative (RESET) pulses |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle end-of-write strobe |

## Verification
The erase pulse appears in the first cycle after the edge that accepts start. After that, the write runs through PULSE_CYCLES erase cycles and GAP_CYCLES gap cycles. Then come the negative pulses, one in binary mode or 2^LEVEL_W-1 in multilevel mode, with gaps only between them. A done cycle follows, and then one idle cycle. The driver turns each start into this exact per-cycle list of expected port values and places it in a queue on the cycle it asserts start. The monitor samples 5 ns after each rising edge and removes one entry per cycle. Because of this, any pulse that starts early or late, or is too long or too short, shifts every later comparison and is caught.

// File: rtl/xws_pkg.sv
package xws_pkg;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_FULL  = 2'd1,
    DRV_THIRD = 2'd2,
    DRV_READ  = 2'd3
  } drvCodeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_GAP,
    ST_PROG,
    ST_DONE
  } seqStateT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic driveSet;
    logic driveReset;
  } seqCtrlT;

endpackage

// File: rtl/xws_ctrl.sv
module xws_ctrl
  import xws_pkg::*;
#(
  parameter int PULSE_CYCLES = 5,
  parameter int GAP_CYCLES   = 2,
  parameter int LEVEL_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               modeMl,
  output seqCtrlT            ctrl,
  output logic [LEVEL_W-1:0] pulseIdx,
  output logic               busy,
  output logic               done
);

  localparam int MAX_LEVEL = (1 << LEVEL_W) - 1;
  localparam int TMR_MAX   = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0]   PULSE_LAST = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [TMR_W-1:0]   GAP_LAST   = TMR_W'(GAP_CYCLES - 1);
  localparam logic [LEVEL_W-1:0] IDX_LAST   = LEVEL_W'(MAX_LEVEL - 1);

  seqStateT          state;
  logic [TMR_W-1:0]  tmr;
  logic              lastPulse;

  assign lastPulse = !modeMl || (pulseIdx == IDX_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      pulseIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_ERASE;
            tmr      <= '0;
            pulseIdx <= '0;
          end
        end
        ST_ERASE: begin
          if (tmr == PULSE_LAST) begin
            state <= ST_GAP;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == GAP_LAST) begin
            state <= ST_PROG;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PROG: begin
          if (tmr == PULSE_LAST) begin
            tmr <= '0;
            if (lastPulse) begin
              state <= ST_DONE;
            end else begin
              state    <= ST_GAP;
              pulseIdx <= pulseIdx + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.capture    = (state == ST_IDLE) && start;
    ctrl.driveSet   = (state == ST_ERASE);
    ctrl.driveReset = (state == ST_PROG);
    busy            = (state == ST_ERASE) || (state == ST_GAP) || (state == ST_PROG);
    done            = (state == ST_DONE);
  end

endmodule

// File: rtl/xws_datapath.sv
module xws_datapath
  import xws_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8,
  parameter int LEVEL_W  = 3,
  parameter int ROW_W    = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtrlT                     ctrl,
  input  logic [LEVEL_W-1:0]          pulseIdx,
  input  logic [ROW_W-1:0]            rowSel,
  input  logic                        multiLevel,
  input  logic [NUM_COLS*LEVEL_W-1:0] colTarget,
  output logic [NUM_ROWS*2-1:0]       rowDrive,
  output logic [NUM_COLS*2-1:0]       colDrive,
  output logic                        negPulse,
  output logic                        modeMl
);

  logic [ROW_W-1:0]            rowQ;
  logic [NUM_COLS*LEVEL_W-1:0] tgtQ;
  logic                        pulseOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      tgtQ   <= '0;
      modeMl <= 1'b0;
    end else if (ctrl.capture) begin
      rowQ   <= rowSel;
      tgtQ   <= colTarget;
      modeMl <= multiLevel;
    end
  end

  assign pulseOn  = ctrl.driveSet || ctrl.driveReset;
  assign negPulse = ctrl.driveReset;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic hit;
    assign hit = (rowQ == ROW_W'(r));
    always_comb begin
      if (!pulseOn)  rowDrive[r*2 +: 2] = DRV_OFF;
      else if (hit)  rowDrive[r*2 +: 2] = DRV_FULL;
      else           rowDrive[r*2 +: 2] = DRV_THIRD;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [LEVEL_W-1:0] tgt;
    logic               colHit;
    assign tgt    = tgtQ[c*LEVEL_W +: LEVEL_W];
    assign colHit = modeMl ? (pulseIdx < tgt) : (tgt != '0);
    always_comb begin
      if (ctrl.driveSet)        colDrive[c*2 +: 2] = DRV_FULL;
      else if (ctrl.driveReset) colDrive[c*2 +: 2] = colHit ? DRV_FULL : DRV_THIRD;
      else                      colDrive[c*2 +: 2] = DRV_OFF;
    end
  end

endmodule

// File: rtl/xbar_write_seq.sv
module xbar_write_seq
  import xws_pkg::*;
#(
  parameter int NUM_ROWS     = 8,
  parameter int NUM_COLS     = 8,
  parameter int LEVEL_W      = 3,
  parameter int PULSE_CYCLES = 5,
  parameter int GAP_CYCLES   = 2,
  parameter int ROW_W        = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [ROW_W-1:0]            rowSel,
  input  logic                        multiLevel,
  input  logic [NUM_COLS*LEVEL_W-1:0] colTarget,
  output logic [NUM_ROWS*2-1:0]       rowDrive,
  output logic [NUM_COLS*2-1:0]       colDrive,
  output logic                        negPulse,
  output logic                        busy,
  output logic                        done
);

  seqCtrlT            ctrl;
  logic [LEVEL_W-1:0] pulseIdx;
  logic               modeMl;

  xws_ctrl #(
    .PULSE_CYCLES(PULSE_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES),
    .LEVEL_W     (LEVEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .modeMl  (modeMl),
    .ctrl    (ctrl),
    .pulseIdx(pulseIdx),
    .busy    (busy),
    .done    (done)
  );

  xws_datapath #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_COLS(NUM_COLS),
    .LEVEL_W (LEVEL_W),
    .ROW_W   (ROW_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .pulseIdx  (pulseIdx),
    .rowSel    (rowSel),
    .multiLevel(multiLevel),
    .colTarget (colTarget),
    .rowDrive  (rowDrive),
    .colDrive  (colDrive),
    .negPulse  (negPulse),
    .modeMl    (modeMl)
  );

endmodule

// File: rtl/xbar_write_seq_chk.sv
module xbar_write_seq_chk #(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [NUM_ROWS*2-1:0] rowDrive,
  input logic [NUM_COLS*2-1:0] colDrive,
  input logic                  negPulse,
  input logic                  busy,
  input logic                  done
);

  logic [NUM_ROWS-1:0] fullMask;
  logic [NUM_COLS*2-1:0] allFull;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_r
    assign fullMask[r] = (rowDrive[r*2 +: 2] == 2'd1);
    p_no_read_row_r8: assert property (@(posedge clk) disable iff (!rstN)
      rowDrive[r*2 +: 2] != 2'd3);
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_c
    assign allFull[c*2 +: 2] = 2'd1;
    p_no_read_col_r8: assert property (@(posedge clk) disable iff (!rstN)
      colDrive[c*2 +: 2] != 2'd3);
  end

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (rowDrive == '0 && colDrive == '0 && !negPulse));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  p_erase_cols_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !negPulse && rowDrive != '0) |-> colDrive == allFull);

  p_gap_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rowDrive == '0) |-> (colDrive == '0 && !negPulse));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && rowDrive == '0 && colDrive == '0));

  p_one_row_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rowDrive != '0) |-> $countones(fullMask) == 1);

  p_row_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && fullMask != '0 && $past(fullMask) != '0)
      |-> $stable(fullMask));

endmodule

bind xbar_write_seq xbar_write_seq_chk #(
  .NUM_ROWS(NUM_ROWS),
  .NUM_COLS(NUM_COLS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .rowDrive(rowDrive),
  .colDrive(colDrive),
  .negPulse(negPulse),
  .busy    (busy),
  .done    (done)
);

// File: tb/xbar_write_seq_bench.sv
module xbar_write_seq_bench;

  localparam int NR = 8;
  localparam int NC = 8;
  localparam int LW = 3;
  localparam int PC = 5;
  localparam int GC = 2;
  localparam int RW = 3;
  localparam int MAXL = (1 << LW) - 1;

  typedef struct packed {
    logic [NR*2-1:0] rowD;
    logic [NC*2-1:0] colD;
    logic            neg;
    logic            busy;
    logic            done;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] rowSel = '0;
  logic multiLevel = 1'b0;
  logic [NC*LW-1:0] colTarget = '0;
  logic [NR*2-1:0] rowDrive;
  logic [NC*2-1:0] colDrive;
  logic negPulse, busy, done;

  int nChecks = 0;
  int nBad = 0;
  expT   expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  xbar_write_seq #(
    .NUM_ROWS(NR), .NUM_COLS(NC), .LEVEL_W(LW),
    .PULSE_CYCLES(PC), .GAP_CYCLES(GC)
  ) u_xbar_write_seq (
    .clk(clk), .rstN(rstN), .start(start), .rowSel(rowSel),
    .multiLevel(multiLevel), .colTarget(colTarget),
    .rowDrive(rowDrive), .colDrive(colDrive), .negPulse(negPulse),
    .busy(busy), .done(done)
  );

  // row codes: selected row FULL=1, others THIRD=2, off=0
  function automatic logic [NR*2-1:0] rowVec(int row, bit on);
    logic [NR*2-1:0] v;
    for (int r = 0; r < NR; r++)
      v[r*2 +: 2] = !on ? 2'd0 : ((r == row) ? 2'd1 : 2'd2);
    return v;
  endfunction

  // kind: 0 off, 1 erase, 2 binary program, 3 multilevel pulse k
  function automatic logic [NC*2-1:0] colVec(int kind, logic [NC*LW-1:0] tgt, int k);
    logic [NC*2-1:0] v;
    for (int c = 0; c < NC; c++) begin
      int t;
      t = int'(tgt[c*LW +: LW]);
      case (kind)
        1:       v[c*2 +: 2] = 2'd1;
        2:       v[c*2 +: 2] = (t != 0) ? 2'd1 : 2'd2;
        3:       v[c*2 +: 2] = (k < t) ? 2'd1 : 2'd2;
        default: v[c*2 +: 2] = 2'd0;
      endcase
    end
    return v;
  endfunction

  task automatic pushItem(expT e, string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic pushRun(int row, bit ml, logic [NC*LW-1:0] tgt);
    expT e;
    int np;
    np = ml ? MAXL : 1;
    for (int i = 0; i < PC; i++) begin
      e = '{rowVec(row, 1), colVec(1, tgt, 0), 1'b0, 1'b1, 1'b0};
      pushItem(e, "R3 erase");
    end
    for (int k = 0; k < np; k++) begin
      for (int i = 0; i < GC; i++) begin
        e = '{rowVec(row, 0), colVec(0, tgt, 0), 1'b0, 1'b1, 1'b0};
        pushItem(e, "R4 gap");
      end
      for (int i = 0; i < PC; i++) begin
        e = '{rowVec(row, 1), colVec(ml ? 3 : 2, tgt, k), 1'b1, 1'b1, 1'b0};
        pushItem(e, ml ? "R6 multilevel pulse" : "R5 binary pulse");
      end
    end
    e = '{rowVec(row, 0), colVec(0, tgt, 0), 1'b0, 1'b0, 1'b1};
    pushItem(e, "R7 done");
    e = '{rowVec(row, 0), colVec(0, tgt, 0), 1'b0, 1'b0, 1'b0};
    pushItem(e, "R1 idle after write");
  endtask

  task automatic runWrite(int row, bit ml, logic [NC*LW-1:0] tgt, bit intrude);
    @(posedge clk); #7;
    rowSel = RW'(row); multiLevel = ml; colTarget = tgt; start = 1'b1;
    pushRun(row, ml, tgt);
    @(posedge clk); #7;
    start = 1'b0;
    if (intrude) begin
      // R2: start during a write must not disturb it
      repeat (3) @(posedge clk);
      #7;
      rowSel = RW'(row ^ 1); multiLevel = !ml; colTarget = ~tgt; start = 1'b1;
      @(posedge clk); #7;
      start = 1'b0;
      repeat (12) @(posedge clk);
      #7;
      start = 1'b1;
      @(posedge clk); #7;
      start = 1'b0;
    end
    wait (expQ.size() == 0);
  endtask

  // monitor
  always begin
    @(posedge clk);
    #5;
    if (expQ.size() > 0) begin
      expT e;
      string t;
      int nFull;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (rowDrive !== e.rowD || colDrive !== e.colD || negPulse !== e.neg ||
          busy !== e.busy || done !== e.done) begin
        nBad++;
        $display("FAIL %s: actual row=%h col=%h neg=%b busy=%b done=%b expected row=%h col=%h neg=%b busy=%b done=%b",
                 t, rowDrive, colDrive, negPulse, busy, done,
                 e.rowD, e.colD, e.neg, e.busy, e.done);
      end
      // R8 and R9 on every sampled cycle of a write
      nFull = 0;
      nChecks++;
      for (int i = 0; i < NR; i++) begin
        if (rowDrive[i*2 +: 2] == 2'd1) nFull++;
        if (rowDrive[i*2 +: 2] == 2'd3) begin
          nBad++;
          $display("FAIL R8: actual row code 3 on row %0d expected not 3", i);
        end
      end
      for (int i = 0; i < NC; i++)
        if (colDrive[i*2 +: 2] == 2'd3) begin
          nBad++;
          $display("FAIL R8: actual column code 3 on col %0d expected not 3", i);
        end
      if (rowDrive != '0 && nFull != 1) begin
        nBad++;
        $display("FAIL R9: actual full rows=%0d expected 1", nFull);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R7: actual hang expected write completion");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    nChecks++;
    if (rowDrive !== '0 || colDrive !== '0 || negPulse !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
      nBad++;
      $display("FAIL R1 reset: actual row=%h col=%h neg=%b busy=%b done=%b expected all 0",
               rowDrive, colDrive, negPulse, busy, done);
    end
    #2 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R5 R10: binary, mixed targets (col0 lsb)
    runWrite(2, 1'b0, {3'd0, 3'd5, 3'd0, 3'd1, 3'd7, 3'd0, 3'd2, 3'd0}, 1'b0);
    // R5: binary, all-zero targets -> all columns THIRD
    runWrite(0, 1'b0, '0, 1'b0);
    // R6 R10: multilevel, target c on column c
    runWrite(7, 1'b1, {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 1'b0);
    // R2: multilevel with starts during the write
    runWrite(5, 1'b1, {3'd7, 3'd0, 3'd7, 3'd1, 3'd6, 3'd3, 3'd7, 3'd2}, 1'b1);
    // R5: binary after multilevel, all nonzero
    runWrite(3, 1'b0, {8{3'd4}}, 1'b0);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule